// File: doc/BRIEF.md
# Trap Entry and Return Controller

This block steers control flow for a core that has a privileged firmware mode. A fault code with a strobe, or a return-from-exception request, produces a registered redirect: a target PC, the PC that follows it, and (for traps) a write of the restart address into the saved-exception-address register kept outside the block. Trap targets come from a fixed table of offsets added to a programmable firmware base. Bit 0 of a PC marks firmware mode.

The block also owns one bank-select bit for the integer register file. A fixed subset of register numbers is steered to an alternate bank while the bit is set. Entering firmware from normal mode sets the bit. A return whose target lies outside firmware clears it. The bit changes on the cycle after the redirect that caused the change. Setting it while it is already set, or clearing it while it is already clear, raises a sticky error flag. When reset is released, the block issues a single redirect to the reset vector, and the bank is already selected.

Top module: `trap_redirect_ctrl`

## Requirements
- R1: Fault codes and vector offsets are: 1 reset 0x0001, 2 machine check 0x0401, 3 arithmetic 0x0501, 16 integer overflow 0x0501, 4 interrupt 0x0101, 5 native data-TLB miss 0x0201, 6 firmware data-TLB miss 0x0281, 7 alignment 0x0301, 8 data-TLB fault 0x0381, 9 data access violation 0x0381, 10 instruction-TLB miss 0x0181, 11 instruction-TLB fault 0x0181, 12 instruction access violation 0x0081, 13 unimplemented opcode 0x0481, 14 FP disabled 0x0581, 15 firmware call 0x2001.
- R2: A trap with a listed code, strobed in cycle N, gives `redir_vld`=1 in cycle N+1 with `redir_pc` = `fw_base` + offset (modulo 2^AW) and `redir_npc` = `redir_pc` + 4.
- R3: During reset `bank_sel`=1, `redir_vld`=0 and `bank_err`=0. Exactly three clock edges after `rst_n` rises, one redirect to `fw_base` + 0x0001 appears, with no restart-address write and no change to the bank.
- R4: A listed trap writes `epc_wdata` = `cur_pc` with `epc_we`=1 in cycle N+1. The exception is an interrupt (code 4) taken while `cur_pc[0]`=1: then `epc_we` stays 0.
- R5: A firmware-call trap (code 15) writes `cur_pc` + 4 as the restart address.
- R6: A listed trap sets `bank_sel` in cycle N+2 only when `cur_pc[0]`=0. Otherwise `bank_sel` is unchanged.
- R7: A return request with `cur_pc[0]`=0 gives `eret_illegal`=1 and `redir_vld`=0 in cycle N+1 and leaves `bank_sel` unchanged.
- R8: A return request with `cur_pc[0]`=1 redirects to `saved_epc` (next PC `saved_epc` + 4). It clears `bank_sel` in cycle N+2 only when `saved_epc[0]`=0.
- R9: `rf_bank_alt` is 1 exactly when `bank_sel`=1 and `rf_idx` is in 8..14 or equals 25.
- R10: `bank_err` becomes 1 when a set is applied while the bank is already selected, or a clear while it is already deselected, and stays 1 until reset.
- R11: A strobed code outside the table (0, 17..31) causes no redirect, no write and no bank change. A strobed trap takes priority over a return request in the same cycle, and that return request is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cur_pc | input | AW | PC of the instruction raising the trap or return |
| trap_vld | input | 1 | Trap strobe |
| trap_code | input | 5 | Trap code (R1) |
| eret_req | input | 1 | Return-from-exception request |
| fw_base | input | AW | Firmware base address |
| saved_epc | input | AW | Current saved exception address |
| rf_idx | input | 5 | Register number being accessed |
| redir_vld | output | 1 | Redirect pulse |
| redir_pc | output | AW | Redirect target |
| redir_npc | output | AW | Target plus 4 |
| epc_we | output | 1 | Saved-address write strobe |
| epc_wdata | output | AW | Saved-address write value |
| bank_sel | output | 1 | Alternate register bank selected |
| rf_bank_alt | output | 1 | Access to `rf_idx` goes to the alternate bank |
| eret_illegal | output | 1 | Return issued outside firmware mode |
| bank_err | output | 1 | Sticky bank-select misuse flag |

## Verification
The temporal assertions rely on two input conditions. The strobe, code, PC and return inputs must be stable for a whole clock cycle. `fw_base` must not change in the cycle the first redirect after reset is formed. The stimulus changes every input only on falling edges, and it sets the base before reset is released. The bench keeps the bank model consistent with R10: before each trap from normal mode it issues a clearing return, unless that part of the test deliberately provokes the error.

// File: rtl/trap_pkg.sv
package trap_pkg;
  localparam int CODE_W = 5;
  localparam int VOFS_W = 14;
  localparam int NREG   = 32;

  typedef enum logic [CODE_W-1:0] {
    TC_NONE     = 5'd0,
    TC_RESET    = 5'd1,
    TC_MCHK     = 5'd2,
    TC_ARITH    = 5'd3,
    TC_INTR     = 5'd4,
    TC_DMISS_N  = 5'd5,
    TC_DMISS_F  = 5'd6,
    TC_ALIGN    = 5'd7,
    TC_DFAULT   = 5'd8,
    TC_DACV     = 5'd9,
    TC_IMISS    = 5'd10,
    TC_IFAULT   = 5'd11,
    TC_IACV     = 5'd12,
    TC_BADOP    = 5'd13,
    TC_FPOFF    = 5'd14,
    TC_FWCALL   = 5'd15,
    TC_OVF      = 5'd16
  } trap_code_e;

  typedef struct packed {
    logic              hit;
    logic [VOFS_W-1:0] ofs;
  } vec_t;

  // Offset table: every entry has bit 0 set so targets land in firmware mode
  function automatic vec_t vec_of(input logic [CODE_W-1:0] c);
    vec_t v;
    v.hit = 1'b1;
    case (c)
      TC_RESET:             v.ofs = 14'h0001;
      TC_IACV:              v.ofs = 14'h0081;
      TC_INTR:              v.ofs = 14'h0101;
      TC_IMISS, TC_IFAULT:  v.ofs = 14'h0181;
      TC_DMISS_N:           v.ofs = 14'h0201;
      TC_DMISS_F:           v.ofs = 14'h0281;
      TC_ALIGN:             v.ofs = 14'h0301;
      TC_DFAULT, TC_DACV:   v.ofs = 14'h0381;
      TC_MCHK:              v.ofs = 14'h0401;
      TC_BADOP:             v.ofs = 14'h0481;
      TC_ARITH, TC_OVF:     v.ofs = 14'h0501;
      TC_FPOFF:             v.ofs = 14'h0581;
      TC_FWCALL:            v.ofs = 14'h2001;
      default: begin
        v.hit = 1'b0;
        v.ofs = '0;
      end
    endcase
    return v;
  endfunction
endpackage

// File: rtl/trap_vec_lookup.sv
module trap_vec_lookup
  import trap_pkg::*;
(
  input  logic [CODE_W-1:0] code_i,
  output logic              hit_o,
  output logic [VOFS_W-1:0] ofs_o
);
  vec_t v;

  always_comb begin
    v     = vec_of(code_i);
    hit_o = v.hit;
    ofs_o = v.ofs;
  end

  // every vector must enter firmware mode (PC bit 0 set)
  always_comb begin
    if (hit_o) begin
      assert_vec_fw_mode_R1: assert (ofs_o[0] == 1'b1);
    end
  end
endmodule

// File: rtl/trap_excaddr_gen.sv
module trap_excaddr_gen
  import trap_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic [AW-1:0]     cur_pc_i,
  input  logic [CODE_W-1:0] code_i,
  output logic              save_o,
  output logic [AW-1:0]     addr_o
);
  localparam logic [AW-1:0] INSN_BYTES = AW'(4);

  logic is_intr;
  logic is_call;

  always_comb begin
    is_intr = (code_i == TC_INTR);
    is_call = (code_i == TC_FWCALL);
    save_o  = !(is_intr && cur_pc_i[0]);
    addr_o  = is_call ? (cur_pc_i + INSN_BYTES) : cur_pc_i;
  end
endmodule

// File: rtl/trap_bank_ctl.sv
module trap_bank_ctl
  import trap_pkg::*;
#(
  parameter logic [NREG-1:0] BANK_MASK = 32'h0200_7F00
) (
  input  logic                    clk,
  input  logic                    rst_ni,
  input  logic                    set_i,
  input  logic                    clr_i,
  input  logic [$clog2(NREG)-1:0] idx_i,
  output logic                    sel_o,
  output logic                    alt_o,
  output logic                    err_o
);
  logic sel_q, sel_d;
  logic err_q, err_d;
  logic upd_en;

  always_comb begin
    sel_d  = sel_q;
    err_d  = err_q;
    upd_en = set_i | clr_i;
    if (set_i) begin
      if (sel_q) err_d = 1'b1;
      sel_d = 1'b1;
    end else if (clr_i) begin
      if (!sel_q) err_d = 1'b1;
      sel_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q <= 1'b1;
      err_q <= 1'b0;
    end else if (upd_en) begin
      sel_q <= sel_d;
      err_q <= err_d;
    end
  end

  assign sel_o = sel_q;
  assign err_o = err_q;
  assign alt_o = sel_q & BANK_MASK[idx_i];

  assert_bank_rise_R6: assert property (@(posedge clk) disable iff (!rst_ni)
    $rose(sel_o) |-> $past(set_i));
  assert_bank_fall_R8: assert property (@(posedge clk) disable iff (!rst_ni)
    $fell(sel_o) |-> $past(clr_i));
  assert_err_sticky_R10: assert property (@(posedge clk) disable iff (!rst_ni)
    $past(err_o) |-> err_o);
  assert_alt_needs_sel_R9: assert property (@(posedge clk) disable iff (!rst_ni)
    alt_o |-> sel_o);
endmodule

// File: rtl/trap_redirect_ctrl.sv
module trap_redirect_ctrl
  import trap_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AW-1:0]     cur_pc,
  input  logic              trap_vld,
  input  logic [CODE_W-1:0] trap_code,
  input  logic              eret_req,
  input  logic [AW-1:0]     fw_base,
  input  logic [AW-1:0]     saved_epc,
  input  logic [4:0]        rf_idx,
  output logic              redir_vld,
  output logic [AW-1:0]     redir_pc,
  output logic [AW-1:0]     redir_npc,
  output logic              epc_we,
  output logic [AW-1:0]     epc_wdata,
  output logic              bank_sel,
  output logic              rf_bank_alt,
  output logic              eret_illegal,
  output logic              bank_err
);
  localparam int            PAD_W      = AW - VOFS_W;
  localparam logic [AW-1:0] INSN_BYTES = AW'(4);

  // reset: asserted asynchronously, released through two flops
  logic [1:0] rst_sq;
  logic       rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sq <= 2'b00;
    else        rst_sq <= {rst_sq[0], 1'b1};
  end
  assign rst_ni = rst_sq[1];

  logic boot_q;

  // vector lookup and restart-address computation
  logic [CODE_W-1:0] lk_code;
  logic              lk_hit;
  logic [VOFS_W-1:0] lk_ofs;
  logic              ea_save;
  logic [AW-1:0]     ea_addr;

  assign lk_code = boot_q ? TC_RESET : trap_code;

  trap_vec_lookup u_vec (
    .code_i (lk_code),
    .hit_o  (lk_hit),
    .ofs_o  (lk_ofs)
  );

  trap_excaddr_gen #(.AW(AW)) u_ea (
    .cur_pc_i (cur_pc),
    .code_i   (trap_code),
    .save_o   (ea_save),
    .addr_o   (ea_addr)
  );

  // next-state
  logic          redir_d, epc_we_d, illegal_d, set_d, clr_d;
  logic [AW-1:0] tgt_d, epc_d;

  always_comb begin
    redir_d   = 1'b0;
    epc_we_d  = 1'b0;
    illegal_d = 1'b0;
    set_d     = 1'b0;
    clr_d     = 1'b0;
    tgt_d     = fw_base + {{PAD_W{1'b0}}, lk_ofs};
    epc_d     = ea_addr;
    if (boot_q) begin
      redir_d = 1'b1;
    end else if (trap_vld) begin
      if (lk_hit) begin
        redir_d  = 1'b1;
        epc_we_d = ea_save;
        set_d    = ~cur_pc[0];
      end
    end else if (eret_req) begin
      if (cur_pc[0]) begin
        redir_d = 1'b1;
        tgt_d   = saved_epc;
        clr_d   = ~saved_epc[0];
      end else begin
        illegal_d = 1'b1;
      end
    end
  end

  // registers
  logic set_q, clr_q;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      boot_q       <= 1'b1;
      redir_vld    <= 1'b0;
      epc_we       <= 1'b0;
      eret_illegal <= 1'b0;
      set_q        <= 1'b0;
      clr_q        <= 1'b0;
    end else begin
      boot_q       <= 1'b0;
      redir_vld    <= redir_d;
      epc_we       <= epc_we_d;
      eret_illegal <= illegal_d;
      set_q        <= set_d;
      clr_q        <= clr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      redir_pc  <= '0;
      redir_npc <= '0;
    end else if (redir_d) begin
      redir_pc  <= tgt_d;
      redir_npc <= tgt_d + INSN_BYTES;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)       epc_wdata <= '0;
    else if (epc_we_d) epc_wdata <= epc_d;
  end

  trap_bank_ctl u_bank (
    .clk    (clk),
    .rst_ni (rst_ni),
    .set_i  (set_q),
    .clr_i  (clr_q),
    .idx_i  (rf_idx),
    .sel_o  (bank_sel),
    .alt_o  (rf_bank_alt),
    .err_o  (bank_err)
  );

  assert_epc_from_trap_R4: assert property (@(posedge clk) disable iff (!rst_ni)
    epc_we |-> $past(trap_vld));
  assert_intr_fw_keep_R4: assert property (@(posedge clk) disable iff (!rst_ni)
    ($past(trap_vld) && !$past(boot_q) && $past(trap_code) == TC_INTR && $past(cur_pc[0]))
      |-> !epc_we);
  assert_call_skip_R5: assert property (@(posedge clk) disable iff (!rst_ni)
    (epc_we && $past(trap_code) == TC_FWCALL) |-> epc_wdata == $past(cur_pc) + INSN_BYTES);
  assert_illegal_no_redir_R7: assert property (@(posedge clk) disable iff (!rst_ni)
    eret_illegal |-> (!redir_vld && $past(eret_req) && !$past(cur_pc[0])));
  assert_illegal_vs_trap_R11: assert property (@(posedge clk) disable iff (!rst_ni)
    eret_illegal |-> !$past(trap_vld));
endmodule

// File: tb/test_trap_redirect_ctrl.sv
module test_trap_redirect_ctrl;
  localparam int  AW   = 32;
  localparam time TCLK = 10;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [AW-1:0] cur_pc;
  logic          trap_vld;
  logic [4:0]    trap_code;
  logic          eret_req;
  logic [AW-1:0] fw_base;
  logic [AW-1:0] saved_epc;
  logic [4:0]    rf_idx;
  logic          redir_vld, epc_we, bank_sel, rf_bank_alt, eret_illegal, bank_err;
  logic [AW-1:0] redir_pc, redir_npc, epc_wdata;

  always #(TCLK/2) clk = ~clk;

  trap_redirect_ctrl #(.AW(AW)) i_trap_redirect_ctrl (
    .clk(clk), .rst_n(rst_n), .cur_pc(cur_pc), .trap_vld(trap_vld),
    .trap_code(trap_code), .eret_req(eret_req), .fw_base(fw_base),
    .saved_epc(saved_epc), .rf_idx(rf_idx), .redir_vld(redir_vld),
    .redir_pc(redir_pc), .redir_npc(redir_npc), .epc_we(epc_we),
    .epc_wdata(epc_wdata), .bank_sel(bank_sel), .rf_bank_alt(rf_bank_alt),
    .eret_illegal(eret_illegal), .bank_err(bank_err)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit exp_sh;
  bit exp_err;

  task automatic check(input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // returns {hit, offset} for a code, from R1
  function automatic logic [14:0] exp_vec(input int c);
    case (c)
      1:      return {1'b1, 14'h0001};
      2:      return {1'b1, 14'h0401};
      3, 16:  return {1'b1, 14'h0501};
      4:      return {1'b1, 14'h0101};
      5:      return {1'b1, 14'h0201};
      6:      return {1'b1, 14'h0281};
      7:      return {1'b1, 14'h0301};
      8, 9:   return {1'b1, 14'h0381};
      10, 11: return {1'b1, 14'h0181};
      12:     return {1'b1, 14'h0081};
      13:     return {1'b1, 14'h0481};
      14:     return {1'b1, 14'h0581};
      15:     return {1'b1, 14'h2001};
      default: return 15'h0;
    endcase
  endfunction

  task automatic check_bank();
    check("R6/R8 bank_sel", AW'(bank_sel), AW'(exp_sh));
    check("R10 bank_err", AW'(bank_err), AW'(exp_err));
  endtask

  task automatic do_trap(input int code, input logic [AW-1:0] pc, input bit with_ret);
    logic [14:0]   v;
    logic [AW-1:0] tgt;
    bit            save;
    v   = exp_vec(code);
    tgt = fw_base + AW'(v[13:0]);
    @(negedge clk);
    trap_vld  = 1'b1;
    trap_code = 5'(code);
    cur_pc    = pc;
    eret_req  = with_ret;
    @(negedge clk);
    trap_vld = 1'b0;
    eret_req = 1'b0;
    if (v[14]) begin
      check("R2 redir_vld", AW'(redir_vld), 1);
      check("R1/R2 redir_pc", redir_pc, tgt);
      check("R2 redir_npc", redir_npc, tgt + 4);
      save = !(code == 4 && pc[0]);
      check("R4 epc_we", AW'(epc_we), AW'(save));
      if (save) check("R4/R5 epc_wdata", epc_wdata, (code == 15) ? pc + 4 : pc);
      if (!pc[0]) begin
        if (exp_sh) exp_err = 1'b1;
        exp_sh = 1'b1;
      end
    end else begin
      check("R11 no redirect", AW'(redir_vld), 0);
      check("R11 no write", AW'(epc_we), 0);
    end
    check("R11 eret ignored", AW'(eret_illegal), 0);
    @(negedge clk);
    check_bank();
  endtask

  task automatic do_ret(input logic [AW-1:0] pc, input logic [AW-1:0] epc);
    @(negedge clk);
    eret_req  = 1'b1;
    cur_pc    = pc;
    saved_epc = epc;
    @(negedge clk);
    eret_req = 1'b0;
    if (pc[0]) begin
      check("R8 redir_vld", AW'(redir_vld), 1);
      check("R8 redir_pc", redir_pc, epc);
      check("R8 redir_npc", redir_npc, epc + 4);
      check("R8 not illegal", AW'(eret_illegal), 0);
      if (!epc[0]) begin
        if (!exp_sh) exp_err = 1'b1;
        exp_sh = 1'b0;
      end
    end else begin
      check("R7 eret_illegal", AW'(eret_illegal), 1);
      check("R7 no redirect", AW'(redir_vld), 0);
    end
    check("R8 no epc write", AW'(epc_we), 0);
    @(negedge clk);
    check_bank();
  endtask

  task automatic sweep_rf();
    for (int i = 0; i < 32; i++) begin
      rf_idx = 5'(i);
      #1;
      check("R9 rf_bank_alt", AW'(rf_bank_alt),
            AW'(exp_sh && ((i >= 8 && i <= 14) || i == 25)));
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(TCLK * 150000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    int wait_n;
    rst_n     = 1'b0;
    cur_pc    = '0;
    trap_vld  = 1'b0;
    trap_code = '0;
    eret_req  = 1'b0;
    fw_base   = 32'h0040_0000;
    saved_epc = '0;
    rf_idx    = '0;
    exp_sh    = 1'b1;
    exp_err   = 1'b0;
    repeat (3) @(negedge clk);
    check("R3 reset bank_sel", AW'(bank_sel), 1);
    check("R3 reset redir_vld", AW'(redir_vld), 0);
    check("R3 reset bank_err", AW'(bank_err), 0);
    rst_n  = 1'b1;
    wait_n = 0;
    do begin
      @(negedge clk);
      wait_n++;
    end while (!redir_vld && wait_n < 8);
    check("R3 boot latency", AW'(wait_n), 3);
    check("R3 boot target", redir_pc, 32'h0040_0001);
    check("R3 boot npc", redir_npc, 32'h0040_0005);
    check("R3 boot no write", AW'(epc_we), 0);
    @(negedge clk);
    check("R3 boot single", AW'(redir_vld), 0);
    check_bank();
    sweep_rf();

    for (int b = 0; b < 2; b++) begin
      fw_base = (b == 0) ? 32'h0040_0000 : 32'hFFFF_E000;
      for (int c = 0; c < 32; c++) begin
        for (int p = 0; p < 2; p++) begin
          logic [AW-1:0] pc;
          pc = 32'h0001_2000 + AW'(c << 4) + AW'(p);
          if (p == 0 && exp_sh) do_ret(32'h0000_0101, 32'h0000_8000 + AW'(c << 2));
          do_trap(c, pc, 1'b0);
        end
      end
    end

    // illegal return from normal mode
    do_ret(32'h0000_3000, 32'h0000_5000);
    // return to a firmware address keeps the bank
    if (!exp_sh) do_trap(2, 32'h0000_6000, 1'b0);
    do_ret(32'h0000_6001, 32'h0000_7001);
    sweep_rf();
    // trap beats a return in the same cycle
    do_ret(32'h0000_6001, 32'h0000_7000);
    sweep_rf();
    do_trap(13, 32'h0000_8000, 1'b1);
    do_trap(0, 32'h0000_8000, 1'b1);
    // misuse: second entry from normal mode without a return
    do_trap(7, 32'h0000_9000, 1'b0);
    check("R10 error raised", AW'(bank_err), 1);
    do_ret(32'h0000_9001, 32'h0000_A000);
    check("R10 error sticky", AW'(bank_err), 1);
    finish_run();
  end
endmodule